// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block carries one direction of traffic across a bus-to-bus bridge. Each incoming transaction has a class code and one payload word. The block sorts accepted transactions into four queues: posted writes, non-posted requests (reads and writes together), read completions and write completions. It then issues them on a single output port in an order that keeps producer-consumer semantics intact. An item is never split, combined, merged or dropped. Every accepted transaction leaves exactly once, carrying its own payload.

Every stored entry records how many posted writes were still queued ahead of it when it arrived. This "ahead" count goes down each time a posted write leaves. A request or read completion may issue only when its count has reached zero. Each entry also gets an age stamp, taken from a counter that advances on every accepted item. Among the queue heads that are allowed to go and that the sink will take this cycle, the selector issues the oldest. So a stalled class never holds back others that may legally pass it, and a class that can go is not starved.

The sink gives a per-class take signal, `out_rdy`, with one bit per class code. `out_valid` marks a transfer in that cycle. In the inbound configuration (the default), the block refuses non-posted writes and unknown codes. It acknowledges them with a reject flag and does not store them.

Top module: `ordq_top`

Class codes: 0 posted write, 1 read request, 2 non-posted write request, 3 read completion, 4 write completion; codes 5 to 7 are unknown.

There is no state machine. The control state is four FIFO queues, the per-entry ahead counts and the age counter. All of it clears to empty at reset.

## Requirements
- R1: Posted writes (code 0) leave in exactly the order in which they were accepted.
- R2: A request (code 1 or 2) is never issued while a posted write accepted before it is still queued.
- R3: A read completion (code 3) is never issued while a posted write accepted before it is still queued.
- R4: A posted write issues ahead of earlier requests or completions whose `out_rdy` bit is low. A write completion (code 4) may issue ahead of earlier queued posted writes.
- R5: Requests (codes 1 and 2) leave in the order in which they were accepted.
- R6: Each of the four queues holds DEPTH entries (default 4). When a queue is full, `in_ready` is low only for the codes that map to that queue.
- R7: With REJECT_NP_WRITE=1, code 2 and codes 5 to 7 see `in_ready`=1 and `in_reject`=1 while `in_valid` is high. They are never stored and never issued.
- R8: Every accepted item is issued exactly once with its payload unchanged. Two identical writes yield two outputs.
- R9: `out_valid` is high only when `out_rdy[out_cls]` is high. Among the allowed queue heads, the earliest accepted is issued. An item accepted at a clock edge can issue from the next cycle on.
- R10: After reset, all queues are empty, `out_valid` is low and `in_ready` is high for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming transaction present |
| in_cls | input | 3 | Class code of the incoming transaction |
| in_data | input | DW | Payload word |
| in_ready | output | 1 | Transaction taken (stored or rejected) at this edge |
| in_reject | output | 1 | Incoming transaction is refused and not stored |
| out_rdy | input | 5 | Sink takes an item of class code i this cycle when bit i is high |
| out_valid | output | 1 | An item is transferred this cycle |
| out_cls | output | 3 | Class code of the issued item |
| out_data | output | DW | Payload of the issued item |

## Verification
The bench goes after four corner cases:
- A read request or read completion sitting behind a posted write while only its own class is ready. A design that ignores the ahead count lets it overtake the write.
- A posted write arriving behind stalled non-posted traffic. A design that serialises all classes deadlocks or stalls the write.
- A full queue. Here `in_ready` must fall for that class alone; a shared full flag would stall unrelated codes.
- Back-to-back identical posted writes and refused write requests. A merging design would lose one of the writes, and a leaky reject path would emit the refused item.

// File: rtl/ordq_pkg.sv
package ordq_pkg;

    localparam int NQ = 4;
    localparam int QW = 2;

    localparam logic [2:0] C_PW    = 3'd0;
    localparam logic [2:0] C_RDREQ = 3'd1;
    localparam logic [2:0] C_WRREQ = 3'd2;
    localparam logic [2:0] C_RDCPL = 3'd3;
    localparam logic [2:0] C_WRCPL = 3'd4;

    typedef enum logic [QW-1:0] {
        Q_POSTED = 2'd0,
        Q_REQ    = 2'd1,
        Q_RCPL   = 2'd2,
        Q_WCPL   = 2'd3
    } queue_e;

    function automatic queue_e queue_of(input logic [2:0] c);
        unique case (c)
            C_PW:             return Q_POSTED;
            C_RDREQ, C_WRREQ: return Q_REQ;
            C_RDCPL:          return Q_RCPL;
            default:          return Q_WCPL;
        endcase
    endfunction

endpackage

// File: rtl/ordq_fifo.sv
module ordq_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AGEW  = 8,
    parameter int AHW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [2:0]      push_cls,
    input  logic [DW-1:0]   push_data,
    input  logic [AGEW-1:0] push_stamp,
    input  logic [AHW-1:0]  push_ahead,
    input  logic            pop,
    input  logic            dec,
    output logic            full,
    output logic            empty,
    output logic [AHW-1:0]  count,
    output logic [2:0]      head_cls,
    output logic [DW-1:0]   head_data,
    output logic [AGEW-1:0] head_stamp,
    output logic [AHW-1:0]  head_ahead
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IW-1:0]   rd_q, wr_q;
    logic [AHW-1:0]  cnt_q;
    logic [2:0]      cls_m   [DEPTH];
    logic [DW-1:0]   data_m  [DEPTH];
    logic [AGEW-1:0] stamp_m [DEPTH];
    logic [AHW-1:0]  ahead_m [DEPTH];

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            cls_m[wr_q]   <= push_cls;
            data_m[wr_q]  <= push_data;
            stamp_m[wr_q] <= push_stamp;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                ahead_m[i] <= '0;
            else if (push && wr_q == IW'(i))
                ahead_m[i] <= push_ahead;
            else if (dec && ahead_m[i] != '0)
                ahead_m[i] <= ahead_m[i] - 1'b1;
        end
    end

    always_comb begin
        count      = cnt_q;
        full       = (cnt_q == AHW'(DEPTH));
        empty      = (cnt_q == '0);
        head_cls   = cls_m[rd_q];
        head_data  = data_m[rd_q];
        head_stamp = stamp_m[rd_q];
        head_ahead = ahead_m[rd_q];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != AHW'(DEPTH)));                        // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));                                  // R8

endmodule

// File: rtl/ordq_arb.sv
module ordq_arb
    import ordq_pkg::*;
#(
    parameter int AGEW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NQ-1:0]             ok,
    input  logic [NQ-1:0][AGEW-1:0]   stamp,
    output logic [NQ-1:0]             grant
);

    function automatic logic older(input logic [AGEW-1:0] a, input logic [AGEW-1:0] b);
        logic [AGEW-1:0] d;
        d = a - b;
        return d[AGEW-1];
    endfunction

    logic [QW-1:0] best;
    logic          found;

    always_comb begin
        best  = '0;
        found = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (ok[q] && (!found || older(stamp[q], stamp[best]))) begin
                best  = QW'(q);
                found = 1'b1;
            end
        end
        grant = found ? (NQ'(1) << best) : '0;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                        // R9
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~ok) == '0);                                    // R2

endmodule

// File: rtl/ordq_top.sv
module ordq_top
    import ordq_pkg::*;
#(
    parameter int DEPTH           = 4,
    parameter int DW              = 32,
    parameter int AGEW            = 8,
    parameter bit REJECT_NP_WRITE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_cls,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          in_reject,
    input  logic [4:0]    out_rdy,
    output logic          out_valid,
    output logic [2:0]    out_cls,
    output logic [DW-1:0] out_data
);

    localparam int AHW = $clog2(DEPTH + 1);

    logic                    bad, accept;
    queue_e                  qsel;
    logic [AGEW-1:0]         age_q;
    logic [NQ-1:0]           push, pop, full, empty, ok;
    logic [NQ-1:0][AHW-1:0]  cnt, hd_ahead;
    logic [NQ-1:0][2:0]      hd_cls;
    logic [NQ-1:0][DW-1:0]   hd_data;
    logic [NQ-1:0][AGEW-1:0] hd_stamp;
    logic [AHW-1:0]          pw_left;

    always_comb begin
        bad       = (in_cls > C_WRCPL) || (REJECT_NP_WRITE && in_cls == C_WRREQ);
        qsel      = queue_of(in_cls);
        in_ready  = bad ? 1'b1 : !full[qsel];
        in_reject = in_valid && bad;
        accept    = in_valid && in_ready && !bad;
        pw_left   = cnt[Q_POSTED] - AHW'(pop[Q_POSTED]);
        for (int q = 0; q < NQ; q++) begin
            push[q] = accept && (qsel == queue_e'(q));
            ok[q]   = !empty[q] && (hd_ahead[q] == '0) && out_rdy[hd_cls[q]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      age_q <= '0;
        else if (accept) age_q <= age_q + 1'b1;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [AHW-1:0] ahead_in;
        logic           dec_in;
        if (q == Q_REQ || q == Q_RCPL) begin : g_ord
            assign ahead_in = pw_left;
            assign dec_in   = pop[Q_POSTED];
        end else begin : g_free
            assign ahead_in = '0;
            assign dec_in   = 1'b0;
        end
        ordq_fifo #(.DEPTH(DEPTH), .DW(DW), .AGEW(AGEW), .AHW(AHW)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push[q]),
            .push_cls   (in_cls),
            .push_data  (in_data),
            .push_stamp (age_q),
            .push_ahead (ahead_in),
            .pop        (pop[q]),
            .dec        (dec_in),
            .full       (full[q]),
            .empty      (empty[q]),
            .count      (cnt[q]),
            .head_cls   (hd_cls[q]),
            .head_data  (hd_data[q]),
            .head_stamp (hd_stamp[q]),
            .head_ahead (hd_ahead[q])
        );
    end

    ordq_arb #(.AGEW(AGEW)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .ok    (ok),
        .stamp (hd_stamp),
        .grant (pop)
    );

    always_comb begin
        out_valid = |pop;
        out_cls   = '0;
        out_data  = '0;
        for (int q = 0; q < NQ; q++) begin
            if (pop[q]) begin
                out_cls  = hd_cls[q];
                out_data = hd_data[q];
            end
        end
    end

    AST_OUT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_rdy[out_cls]);                         // R9
    AST_REJECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_reject |-> in_ready);                                 // R7
    AST_RCPL_BEHIND_PW: assert property (@(posedge clk) disable iff (!rst_n)
        !empty[Q_RCPL] |-> (hd_ahead[Q_RCPL] <= cnt[Q_POSTED])); // R3
    AST_REQ_BEHIND_PW: assert property (@(posedge clk) disable iff (!rst_n)
        !empty[Q_REQ] |-> (hd_ahead[Q_REQ] <= cnt[Q_POSTED]));   // R2

endmodule

// File: tb/sim_ordq_top.sv
`timescale 1ns/1ps
module sim_ordq_top;

    localparam int DEPTH = 4;
    localparam int DW    = 32;

    typedef struct { int cls; int data; } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_cls = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, in_reject;
    logic [4:0]    out_rdy = '0;
    logic          out_valid;
    logic [2:0]    out_cls;
    logic [DW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    item_t pending[$];

    always #4 clk = ~clk;

    ordq_top #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_data(in_data), .in_ready(in_ready), .in_reject(in_reject),
        .out_rdy(out_rdy), .out_valid(out_valid), .out_cls(out_cls),
        .out_data(out_data)
    );

    function automatic int qid(input int c);
        if (c == 0) return 0;
        if (c == 1 || c == 2) return 1;
        if (c == 3) return 2;
        return 3;
    endfunction

    function automatic bit refused(input int c);
        return (c > 4) || (c == 2);
    endfunction

    function automatic int qcount(input int q);
        int n = 0;
        foreach (pending[i]) if (qid(pending[i].cls) == q) n++;
        return n;
    endfunction

    function automatic int pick(input logic [4:0] r);
        foreach (pending[i]) begin
            bit elig = r[pending[i].cls];
            for (int j = 0; j < i; j++) begin
                if (qid(pending[j].cls) == qid(pending[i].cls)) elig = 0;
                if (pending[j].cls == 0 && pending[i].cls >= 1 && pending[i].cls <= 3) elig = 0;
            end
            if (elig) return i;
        end
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit v, input int c, input int d, input logic [4:0] r);
        int k;
        bit er;
        @(negedge clk);
        in_valid = v;
        in_cls   = 3'(c);
        in_data  = DW'(d);
        out_rdy  = r;
        #2;
        er = refused(c) ? 1'b1 : (qcount(qid(c)) < DEPTH);
        k  = pick(r);
        chk(tag, "in_ready", int'(in_ready), int'(er));
        chk(tag, "in_reject", int'(in_reject), int'(v && refused(c)));
        chk(tag, "out_valid", int'(out_valid), int'(k >= 0));
        if (k >= 0) begin
            chk(tag, "out_cls", int'(out_cls), pending[k].cls);
            chk(tag, "out_data", int'(out_data), pending[k].data);
            pending.delete(k);
        end
        if (v && er && !refused(c)) pending.push_back('{cls: c, data: d});
    endtask

    task automatic idle(input string tag, input int n, input logic [4:0] r);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: empty after reset, ready for every code
        step("R10", 0, 0, 0, 5'b11111);
        step("R10", 0, 3, 0, 5'b11111);
        // R1: posted writes keep order
        step("R1", 1, 0, 11, 5'b00000);
        step("R1", 1, 0, 12, 5'b00000);
        step("R1", 1, 0, 13, 5'b00000);
        idle("R1", 4, 5'b11111);
        // R2: read request held behind posted write
        step("R2", 1, 0, 21, 5'b00000);
        step("R2", 1, 1, 22, 5'b00000);
        idle("R2", 2, 5'b00010);
        idle("R2", 3, 5'b11111);
        // R3: read completion held behind posted write
        step("R3", 1, 0, 31, 5'b00000);
        step("R3", 1, 3, 32, 5'b00000);
        idle("R3", 2, 5'b01000);
        idle("R3", 3, 5'b11111);
        // R4: posted write passes stalled request; write completion passes posted write
        step("R4", 1, 1, 41, 5'b00000);
        step("R4", 1, 0, 42, 5'b00000);
        idle("R4", 1, 5'b00001);
        step("R4", 1, 0, 43, 5'b00000);
        step("R4", 1, 4, 44, 5'b00000);
        idle("R4", 1, 5'b10000);
        idle("R4", 3, 5'b11111);
        // R5: requests in arrival order
        step("R5", 1, 1, 51, 5'b00000);
        step("R5", 1, 1, 52, 5'b00000);
        step("R5", 1, 1, 53, 5'b00000);
        idle("R5", 4, 5'b11111);
        // R6: full read-completion queue stalls only its own code
        for (int i = 0; i < 4; i++) step("R6", 1, 3, 61 + i, 5'b00000);
        step("R6", 1, 3, 65, 5'b00000);
        step("R6", 1, 0, 66, 5'b00000);
        idle("R6", 6, 5'b11111);
        // R7: refused codes are flagged and never issued
        step("R7", 1, 2, 71, 5'b11111);
        step("R7", 1, 6, 72, 5'b11111);
        step("R7", 1, 7, 73, 5'b11111);
        idle("R7", 2, 5'b11111);
        // R8: identical writes are not collapsed
        step("R8", 1, 0, 81, 5'b00000);
        step("R8", 1, 0, 81, 5'b00000);
        idle("R8", 3, 5'b11111);
        // R9: mixed traffic with random sink readiness
        for (int i = 0; i < 3000; i++)
            step("R9", 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 1000 + i, 5'($urandom));
        idle("R9", 25, 5'b11111);
        chk("R8", "left_pending", pending.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule